// File: doc/BRIEF.md
# Sparse Multi-Master Bus Crossbar

This block joins several bus masters to several slaves through a fixed, sparse switch map. Only the master/slave crossings named in a connectivity parameter carry a path; a request aimed at any other crossing, or at an address outside every slave region, is answered with a one-cycle error and never reaches a slave.

Each slave has its own arbiter that holds one owner at a time. A request to an idle slave is granted on the next clock edge. The owner's address, direction and write data are then steered to that slave. The slave's ready signal, which it may hold low to add wait states, is returned to the owner together with the read data. Single transfers from competing masters take turns in round-robin order. A master that asks for a 4, 8 or 16 beat burst keeps the slave until its final beat completes, and every other master waiting on that slave stalls until then.

The two high address bits select the slave region. Masters step their own address from beat to beat within a burst.

Top module: `sparse_xbar`

## Requirements
- R1: A master reaches a slave only where its bit m*NS+s of CONN_MAP is set. The default map is master0 to slaves 0,1,2; master1 to slaves 0,1; master2 to slaves 1,2. A request at an unset crossing asserts m_ready_o and m_err_o together one cycle after the request and selects no slave.
- R2: Address bits [7:6] choose the slave: values 0 to 2 are slaves 0 to 2, and value 3 is a decode miss that gets the same one-cycle error response as R1.
- R3: At any time each slave has at most one owning master, and each master owns at most one slave.
- R4: A request to an idle, connected slave is granted on the next edge. While granted, s_sel_o, s_addr_o, s_we_o and s_wdata_o carry the owner's values, and the owner's m_rdata_o carries the slave's s_rdata_i. After reset no ready, error or select output is high.
- R5: The owner's m_ready_o is high only in cycles where the slave's s_ready_i is high. With W wait states, a single transfer to an idle slave shows ready 1+W cycles after the request.
- R6: When the slave is released, the next owner is the first requesting master at or after the one following the previous winner, in increasing index order with wrap-around. The master that has just finished is excluded from that choice.
- R7: m_blen_i code 0 is a single transfer and codes 1, 2 and 3 are bursts of 4, 8 and 16 beats. The burst owner keeps the slave until its last beat completes, so a master that asks one cycle after a burst starts on a zero-wait slave sees ready only after all beats are done.
- R8: Two masters issuing back-to-back single transfers to the same zero-wait slave alternate, one completion per cycle.
- R9: A request that gets an error response writes nothing in any slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m_req_i | input | NM | Per-master transfer request |
| m_addr_i | input | NM*AW | Per-master address |
| m_we_i | input | NM | Per-master write enable |
| m_wdata_i | input | NM*DW | Per-master write data |
| m_blen_i | input | NM*2 | Per-master burst length code |
| m_rdata_o | output | NM*DW | Read data returned to each master |
| m_ready_o | output | NM | Transfer (or error) completes this cycle |
| m_err_o | output | NM | Error response (miss or no switch) |
| s_sel_o | output | NS | Slave selected for a transfer |
| s_addr_o | output | NS*AW | Address steered to each slave |
| s_we_o | output | NS | Write enable steered to each slave |
| s_wdata_o | output | NS*DW | Write data steered to each slave |
| s_rdata_i | input | NS*DW | Read data from each slave |
| s_ready_i | input | NS | Slave ready; low inserts a wait state |

## Verification
The assertions assume that a master holds its request, address and burst code steady until it sees ready. They also assume that a master with a burst grant keeps requesting until the last beat, and that a slave raises ready only while it is selected. The stimulus obeys these rules by construction. Each master is driven by a task that changes its inputs only just after a completion edge. The bench's slave models derive ready from their own wait-state counters, which run only while select is high.

// File: rtl/sxb_pkg.sv
package sxb_pkg;
  typedef logic [1:0] blen_t;
  localparam int unsigned MAX_BEATS = 16;

  function automatic logic [4:0] beats_of(input blen_t code);
    case (code)
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      2'd3:    return 5'd16;
      default: return 5'd1;
    endcase
  endfunction
endpackage

// File: rtl/sxb_decode.sv
module sxb_decode #(
  parameter int NM = 3,
  parameter int NS = 3,
  parameter int XW = 2,
  parameter logic [NM*NS-1:0] CONN_MAP = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NM-1:0]    req_i,
  input  logic [NM*XW-1:0] idx_i,
  output logic [NM-1:0]    hit_o,
  output logic [NM-1:0]    err_o
);
  for (genvar m = 0; m < NM; m++) begin : g_m
    logic [XW-1:0] idx;
    logic          hit;
    logic          err_q;

    assign idx = idx_i[m*XW +: XW];

    // hit only where a switch exists at this crossing
    always_comb begin
      hit = 1'b0;
      for (int s = 0; s < NS; s++) begin
        if (idx == XW'(s) && CONN_MAP[m*NS+s]) hit = 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_q <= 1'b0;
      else         err_q <= req_i[m] && !hit && !err_q;
    end

    assign hit_o[m] = hit;
    assign err_o[m] = err_q;

    assert_err_follows_bad_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |-> $past(req_i[m] && !hit));
  end
endmodule

// File: rtl/sxb_arb.sv
module sxb_arb #(
  parameter int NM = 3,
  parameter int MW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NM-1:0]  req_i,
  input  logic [NM*2-1:0] blen_i,
  input  logic           ready_i,
  output logic           sel_o,
  output logic           own_v_o,
  output logic [MW-1:0]  own_o
);
  import sxb_pkg::*;
  localparam int CW = $clog2(MAX_BEATS);

  logic          own_v_q;
  logic [MW-1:0] own_q;
  logic [MW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic [NM-1:0] own_mask;
  logic [NM-1:0] cand;
  logic          own_req, done, last, free;
  logic          win_v;
  logic [MW-1:0] win;
  int            c;

  assign own_req = own_v_q && req_i[own_q];
  assign done    = own_req && ready_i;
  assign last    = done && (cnt_q == '0);
  assign free    = !own_v_q || !req_i[own_q] || last;

  always_comb begin
    own_mask = '0;
    if (own_v_q) own_mask[own_q] = 1'b1;
  end

  // round robin from ptr; releasing owner is excluded
  always_comb begin
    cand  = req_i & ~own_mask;
    win_v = 1'b0;
    win   = '0;
    c     = 0;
    for (int i = 0; i < NM; i++) begin
      c = int'(ptr_q) + i;
      if (c >= NM) c = c - NM;
      if (!win_v && cand[c]) begin
        win_v = 1'b1;
        win   = MW'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_v_q <= 1'b0;
      own_q   <= '0;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else if (free) begin
      own_v_q <= win_v;
      if (win_v) begin
        own_q <= win;
        ptr_q <= (int'(win) == NM-1) ? '0 : win + 1'b1;
        cnt_q <= CW'(beats_of(blen_i[int'(win)*2 +: 2]) - 5'd1);
      end
    end else if (done) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign sel_o   = own_req;
  assign own_v_o = own_v_q;
  assign own_o   = own_q;

  assert_burst_keeps_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_req && cnt_q != '0) |=> (own_v_q && own_q == $past(own_q)));

  assert_wait_keeps_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_req && !ready_i) |=> (own_v_q && own_q == $past(own_q) && cnt_q == $past(cnt_q)));
endmodule

// File: rtl/sparse_xbar.sv
module sparse_xbar #(
  parameter int NM = 3,
  parameter int NS = 3,
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [NM*NS-1:0] CONN_MAP = 9'b110_011_111
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NM-1:0]    m_req_i,
  input  logic [NM*AW-1:0] m_addr_i,
  input  logic [NM-1:0]    m_we_i,
  input  logic [NM*DW-1:0] m_wdata_i,
  input  logic [NM*2-1:0]  m_blen_i,
  output logic [NM*DW-1:0] m_rdata_o,
  output logic [NM-1:0]    m_ready_o,
  output logic [NM-1:0]    m_err_o,
  output logic [NS-1:0]    s_sel_o,
  output logic [NS*AW-1:0] s_addr_o,
  output logic [NS-1:0]    s_we_o,
  output logic [NS*DW-1:0] s_wdata_o,
  input  logic [NS*DW-1:0] s_rdata_i,
  input  logic [NS-1:0]    s_ready_i
);
  localparam int XW = $clog2(NS + 1);
  localparam int MW = (NM > 1) ? $clog2(NM) : 1;

  logic [NM*XW-1:0] idx;
  logic [NM-1:0]    hit;
  logic [NM-1:0]    err;
  logic [NM-1:0]    sreq [NS];
  logic [NM-1:0]    gnt  [NS];
  logic [NS-1:0]    own_v;
  logic [MW-1:0]    own  [NS];

  for (genvar m = 0; m < NM; m++) begin : g_idx
    assign idx[m*XW +: XW] = m_addr_i[m*AW+AW-1 -: XW];
  end

  sxb_decode #(.NM(NM), .NS(NS), .XW(XW), .CONN_MAP(CONN_MAP)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (m_req_i),
    .idx_i (idx),
    .hit_o (hit),
    .err_o (err)
  );

  for (genvar s = 0; s < NS; s++) begin : g_s
    for (genvar m = 0; m < NM; m++) begin : g_rq
      assign sreq[s][m] = m_req_i[m] && hit[m] && (idx[m*XW +: XW] == XW'(s));
      assign gnt[s][m]  = own_v[s] && (own[s] == MW'(m));
    end

    sxb_arb #(.NM(NM), .MW(MW)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (sreq[s]),
      .blen_i (m_blen_i),
      .ready_i(s_ready_i[s]),
      .sel_o  (s_sel_o[s]),
      .own_v_o(own_v[s]),
      .own_o  (own[s])
    );

    assign s_addr_o[s*AW +: AW]  = m_addr_i[int'(own[s])*AW +: AW];
    assign s_wdata_o[s*DW +: DW] = m_wdata_i[int'(own[s])*DW +: DW];
    assign s_we_o[s]             = m_we_i[own[s]];
  end

  for (genvar m = 0; m < NM; m++) begin : g_m
    logic          rdy;
    logic [DW-1:0] rd;
    logic [NS-1:0] col;

    always_comb begin
      rdy = err[m];
      rd  = '0;
      col = '0;
      for (int s = 0; s < NS; s++) begin
        col[s] = gnt[s][m];
        if (gnt[s][m] && s_sel_o[s]) begin
          rdy = rdy | s_ready_i[s];
          rd  = rd | s_rdata_i[s*DW +: DW];
        end
      end
    end

    assign m_ready_o[m]          = rdy;
    assign m_err_o[m]            = err[m];
    assign m_rdata_o[m*DW +: DW] = rd;

    assert_one_slave_per_master_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col));

    assert_err_never_granted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_err_o[m] |-> (col == '0));

    for (genvar s = 0; s < NS; s++) begin : g_chk
      if (!CONN_MAP[m*NS+s]) begin : g_nc
        assert_no_route_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
          !gnt[s][m]);
      end
      assert_ready_needs_slave_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt[s][m] && s_sel_o[s] && !s_ready_i[s]) |-> !m_ready_o[m]);
    end
  end
endmodule

// File: tb/tb_sparse_xbar.sv
module tb_sparse_xbar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [2:0]  mreq = '0;
  logic [7:0]  maddr [3];
  logic [2:0]  mwe = '0;
  logic [15:0] mwd [3];
  logic [1:0]  mbl [3];

  logic [23:0] m_addr;
  logic [47:0] m_wdata;
  logic [5:0]  m_blen;
  logic [47:0] m_rdata;
  logic [2:0]  m_ready, m_err;
  logic [2:0]  s_sel, s_we, s_ready;
  logic [23:0] s_addr;
  logic [47:0] s_wdata, s_rdata;

  assign m_addr  = {maddr[2], maddr[1], maddr[0]};
  assign m_wdata = {mwd[2], mwd[1], mwd[0]};
  assign m_blen  = {mbl[2], mbl[1], mbl[0]};

  sparse_xbar dut (
    .clk_i(clk), .rst_ni(rst_n),
    .m_req_i(mreq), .m_addr_i(m_addr), .m_we_i(mwe), .m_wdata_i(m_wdata), .m_blen_i(m_blen),
    .m_rdata_o(m_rdata), .m_ready_o(m_ready), .m_err_o(m_err),
    .s_sel_o(s_sel), .s_addr_o(s_addr), .s_we_o(s_we), .s_wdata_o(s_wdata),
    .s_rdata_i(s_rdata), .s_ready_i(s_ready)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  function automatic int wait_of(input int s);
    case (s) 0: return 0; 1: return 3; default: return 1; endcase
  endfunction

  function automatic bit conn(input int m, input int s);
    if (s > 2) return 1'b0;
    case (m)
      0: return 1'b1;
      1: return s != 2;
      default: return s != 0;
    endcase
  endfunction

  function automatic int nbeats(input logic [1:0] c);
    case (c) 2'd1: return 4; 2'd2: return 8; 2'd3: return 16; default: return 1; endcase
  endfunction

  // slave models
  logic [3:0]  wcnt [3];
  logic [15:0] mem [3][64];
  logic [15:0] shadow [4][64];

  for (genvar g = 0; g < 3; g++) begin : g_sl
    assign s_ready[g] = s_sel[g] && (int'(wcnt[g]) == wait_of(g));
    assign s_rdata[g*16 +: 16] = mem[g][s_addr[g*8 +: 6]];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int s = 0; s < 3; s++) begin
      if (!rst_n) wcnt[s] <= '0;
      else if (s_sel[s] && !s_ready[s]) wcnt[s] <= wcnt[s] + 1'b1;
      else wcnt[s] <= '0;
      if (s_sel[s] && s_ready[s] && s_we[s]) mem[s][s_addr[s*8 +: 6]] <= s_wdata[s*16 +: 16];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int m, input logic [7:0] a, input logic we, input logic [15:0] wd,
                      input logic [1:0] bl, output int lat, output logic [15:0] rd,
                      output logic er, output int dcyc, output logic [2:0] selsnap);
    int n;
    n = nbeats(bl);
    lat = 0;
    mreq[m] = 1'b1; maddr[m] = a; mwe[m] = we; mwd[m] = wd; mbl[m] = bl;
    for (int b = 0; b < n; b++) begin
      while (!m_ready[m]) begin
        @(posedge clk); #1;
        if (b == 0) lat++;
      end
      rd = m_rdata[m*16 +: 16];
      er = m_err[m];
      selsnap = s_sel;
      @(posedge clk); #1;
      dcyc = cyc;
      maddr[m] = a + 8'(b + 1);
      mwd[m] = wd + 16'(b + 1);
    end
    mreq[m] = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cyc == 100000) begin
      total++; bad++;
      $display("FAIL watchdog R4 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int lat, lat1, d0a, d0b, d1a, d1b, dd [3], f, dummy;
  logic [15:0] rd, rd1;
  logic er, er1;
  logic [2:0] ss;
  logic [7:0] a;

  initial begin
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 64; i++) begin
        shadow[s][i] = '0;
        if (s < 3) mem[s][i] = '0;
      end
    for (int m = 0; m < 3; m++) begin maddr[m] = '0; mwd[m] = '0; mbl[m] = '0; end
    void'($urandom(32'd1234));

    repeat (3) @(posedge clk);
    #1;
    chk("R4 reset ready", 32'(m_ready), 0);
    chk("R4 reset err", 32'(m_err), 0);
    chk("R4 reset sel", 32'(s_sel), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;

    // directed singles on every connected crossing
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 3; s++)
        if (conn(m, s)) begin
          a = 8'((s << 6) | (m << 4) | 5);
          xfer(m, a, 1'b1, 16'(16'h1000 + m*16 + s), 2'd0, lat, rd, er, dummy, ss);
          shadow[s][a[5:0]] = 16'(16'h1000 + m*16 + s);
          chk("R5 write latency", 32'(lat), 32'(1 + wait_of(s)));
          chk("R4 slave select", 32'(ss), 32'(1 << s));
          chk("R4 no err", 32'(er), 0);
          xfer(m, a, 1'b0, 16'h0, 2'd0, lat, rd, er, dummy, ss);
          chk("R4 read data", 32'(rd), 32'(shadow[s][a[5:0]]));
        end

    // unconnected crossings and decode miss
    xfer(1, 8'h90, 1'b1, 16'hAAAA, 2'd0, lat, rd, er, dummy, ss);
    chk("R1 m1->s2 err", 32'(er), 1);
    chk("R1 m1->s2 latency", 32'(lat), 1);
    chk("R1 m1->s2 no select", 32'(ss), 0);
    xfer(2, 8'h20, 1'b1, 16'hBBBB, 2'd0, lat, rd, er, dummy, ss);
    chk("R1 m2->s0 err", 32'(er), 1);
    chk("R1 m2->s0 no select", 32'(ss), 0);
    xfer(0, 8'hC3, 1'b1, 16'hCCCC, 2'd0, lat, rd, er, dummy, ss);
    chk("R2 miss err", 32'(er), 1);
    chk("R2 miss latency", 32'(lat), 1);
    chk("R2 miss no select", 32'(ss), 0);
    xfer(0, 8'h90, 1'b0, 16'h0, 2'd0, lat, rd, er, dummy, ss);
    chk("R9 s2 untouched", 32'(rd), 0);
    xfer(0, 8'h20, 1'b0, 16'h0, 2'd0, lat, rd, er, dummy, ss);
    chk("R9 s0 untouched", 32'(rd), 0);

    // two masters alternating on zero-wait slave0
    fork
      begin
        xfer(0, 8'h01, 1'b1, 16'h0A01, 2'd0, lat, rd, er, d0a, ss);
        xfer(0, 8'h02, 1'b1, 16'h0A02, 2'd0, lat, rd, er, d0b, ss);
      end
      begin
        xfer(1, 8'h11, 1'b1, 16'h0B01, 2'd0, lat1, rd1, er1, d1a, ss);
        xfer(1, 8'h12, 1'b1, 16'h0B02, 2'd0, lat1, rd1, er1, d1b, ss);
      end
    join
    shadow[0][8'h01] = 16'h0A01; shadow[0][8'h02] = 16'h0A02;
    shadow[0][8'h11] = 16'h0B01; shadow[0][8'h12] = 16'h0B02;
    chk("R8 first pair one apart", 32'((d0a > d1a) ? d0a - d1a : d1a - d0a), 1);
    chk("R8 m0 second after turn", 32'(d0b - d0a), 2);
    chk("R8 m1 second after turn", 32'(d1b - d1a), 2);

    // three masters rotate on slave1 (3 wait states)
    fork
      xfer(0, 8'h41, 1'b0, 16'h0, 2'd0, lat, rd, er, dd[0], ss);
      xfer(1, 8'h51, 1'b0, 16'h0, 2'd0, lat1, rd1, er1, dd[1], ss);
      xfer(2, 8'h61, 1'b0, 16'h0, 2'd0, dummy, rd, er, dd[2], ss);
    join
    f = 0;
    for (int m = 1; m < 3; m++) if (dd[m] < dd[f]) f = m;
    chk("R6 next in order", 32'(dd[(f+1)%3] - dd[f]), 4);
    chk("R6 last in order", 32'(dd[(f+2)%3] - dd[f]), 8);

    // bursts hold slave0 against a later single request
    for (int bl = 1; bl < 4; bl++) begin
      fork
        xfer(0, 8'h00, 1'b1, 16'(16'h5000 + bl*256), 2'(bl), lat, rd, er, dummy, ss);
        begin
          @(posedge clk); #1;
          xfer(1, 8'h15, 1'b0, 16'h0, 2'd0, lat1, rd1, er1, dd[1], ss);
        end
      join
      for (int k = 0; k < nbeats(2'(bl)); k++) shadow[0][k] = 16'(16'h5000 + bl*256 + k);
      chk("R7 waiter stalled for all beats", 32'(lat1), 32'(nbeats(2'(bl))));
      chk("R7 waiter data", 32'(rd1), 32'(shadow[0][8'h15]));
      xfer(0, 8'(nbeats(2'(bl)) - 1), 1'b0, 16'h0, 2'd0, lat, rd, er, dummy, ss);
      chk("R7 last beat written", 32'(rd), 32'(shadow[0][nbeats(2'(bl)) - 1]));
    end

    // random sequential traffic
    for (int it = 0; it < 300; it++) begin
      int m, s, off;
      logic w;
      logic [15:0] d;
      m = $urandom_range(2, 0);
      s = $urandom_range(3, 0);
      off = $urandom_range(15, 0);
      w = 1'($urandom_range(1, 0));
      d = 16'($urandom);
      a = 8'((s << 6) | (m << 4) | off);
      xfer(m, a, w, d, 2'd0, lat, rd, er, dummy, ss);
      if (conn(m, s)) begin
        chk("R1 rand connected no err", 32'(er), 0);
        chk("R5 rand latency", 32'(lat), 32'(1 + wait_of(s)));
        if (w) shadow[s][a[5:0]] = d;
        else chk("R4 rand read", 32'(rd), 32'(shadow[s][a[5:0]]));
      end else begin
        chk("R2 rand error", 32'(er), 1);
        chk("R9 rand no select", 32'(ss), 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule